// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Slave

This block is a two-wire serial slave that owns a bank of eight 8-bit configuration registers. A host writes the bank with a block-write transfer: after the device address it sends two framing bytes (a command code and a byte count), which the slave acknowledges and throws away. The data bytes that follow fill the registers in ascending order starting at register 0. The host may stop after any whole byte, and the bytes already sent are kept.

A block-read transfer returns a byte count of 8 followed by the whole bank, register 0 first. Some fields of the bank are not storage. They mirror inputs of the block: four latched strap levels and five live pin levels. Register 7 is a fixed identification value. These bits ignore writes. The whole register image, including the mirrored fields, is also presented in parallel on `cfg_o` for use by the surrounding logic.

SCL and SDA are sampled with the system clock through two-stage synchronizers. A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. SDA is split into an input, an output value and an output enable.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read). After any other address byte it leaves SDA released and ignores all traffic until the next start.
- R2: In a write, the two bytes after the address (command code and byte count) are each acknowledged, and their values change no register.
- R3: Write data bytes load register 0, 1, 2 and upward in order, and each byte is acknowledged. A stop after any complete byte keeps the bytes already written. A byte cut short by a stop is not stored.
- R4: Data bytes beyond the eighth are acknowledged and discarded.
- R5: In a read, the slave transmits MSB first the value 8, then registers 0 through 7. A host NACK ends transmission, and the slave then releases SDA.
- R6: After reset, register 0 is 0x00, registers 1 to 4 are 0xFF, register 5 bits 3:0 are 1 and register 6 bits 7, 6 and 0 are 0. Register k appears on `cfg_o[8k+7:8k]`.
- R7: Register 7 always reads 0x29 and ignores writes.
- R8: Register 5 bits 7:4 mirror `strap_i[3:0]` and register 6 bits 5:1 mirror `pin_lvl_i[4:0]`. These bits ignore writes. The writable bits are register 5 bits 3:0 and register 6 bits 7, 6 and 0.
- R9: A repeated start returns the slave to the address stage, and the next write begins again at the command code and then register 0.
- R10: The slave enables its SDA driver only during its own acknowledge slots and the bytes it transmits. SDA is released while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_o | output | 1 | Value driven on SDA while enabled |
| sda_oe | output | 1 | SDA driver enable |
| strap_i | input | 4 | Latched strap levels mirrored into register 5 |
| pin_lvl_i | input | 5 | Live pin levels mirrored into register 6 |
| cfg_o | output | 64 | Parallel image of registers 0 to 7 |

## Verification
Each bus pin change passes two synchronizer flops and one edge register, so the slave's SDA output responds in the third clock after an SCL edge. A stored byte appears on `cfg_o` one clock after that. The bench holds every quarter of a bus bit for eight clocks. It reads SDA in the middle of the SCL high phase and checks `cfg_o` only after the stop that closes a transfer, when all responses have long settled. The sweep covers every write length from zero to ten data bytes with changing strap and pin levels, and each write is followed by a full read-back.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  localparam int NREG = 8;
  localparam int BW = 8;
  localparam int STRAP_W = 4;
  localparam int LVL_W = 5;
  localparam logic [BW-2:0] DEV_ADDR = 7'h69;
  localparam logic [BW-1:0] ID_BYTE = 8'h29;
  localparam logic [BW-1:0] COUNT_VAL = 8'd8;
  localparam logic [NREG*BW-1:0] WMASK =
    {8'h00, 8'hC1, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [NREG*BW-1:0] DFLT =
    {8'h00, 8'h00, 8'h0F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};

  typedef enum logic [2:0] {
    L_IDLE, L_RX, L_RX_ACK, L_TX, L_TX_ACK
  } link_st_e;

  typedef enum logic [1:0] {
    SG_ADDR, SG_CMD, SG_CNT, SG_DATA
  } stage_e;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_q, scl_n;
  logic [2:0] sda_q, sda_n;

  always_comb begin
    scl_n = {scl_q[1:0], scl_i};
    sda_n = {sda_q[1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  always_comb begin
    sda_s     = sda_q[1];
    scl_rise  = scl_q[1] & ~scl_q[2];
    scl_fall  = ~scl_q[1] & scl_q[2];
    start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
    stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  end

  a_r9_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !stop_det);
endmodule

// File: rtl/cfgbus_link.sv
module cfgbus_link import cfgbus_pkg::*; #(
  parameter int NREG_P = NREG,
  parameter int BW_P   = BW,
  parameter logic [BW_P-2:0] ADDR_P  = DEV_ADDR,
  parameter logic [BW_P-1:0] COUNT_P = COUNT_VAL,
  localparam int AW = $clog2(NREG_P),
  localparam int PW = $clog2(NREG_P + 2),
  localparam int CW = $clog2(BW_P + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [BW_P-1:0] rd_data,
  output logic [AW-1:0]   rd_addr,
  output logic            wr_stb,
  output logic [AW-1:0]   wr_addr,
  output logic [BW_P-1:0] wr_data,
  output logic            sda_o,
  output logic            sda_oe
);
  link_st_e        st_q, st_n;
  stage_e          stage_q, stage_n;
  logic [CW-1:0]   bit_q, bit_n;
  logic [BW_P-1:0] sh_q, sh_n;
  logic [PW-1:0]   ptr_q, ptr_n;
  logic            rd_q, rd_n;
  logic            oe_q, oe_n;
  logic            obit_q, obit_n;
  logic            mack_q, mack_n;
  logic            stb_n;
  logic [AW-1:0]   waddr_n;
  logic [BW_P-1:0] wdata_n;
  logic [BW_P-1:0] tx_byte;

  always_comb begin
    rd_addr = ptr_q[AW-1:0] - {{(AW-1){1'b0}}, 1'b1};
    tx_byte = (ptr_q == '0) ? COUNT_P : rd_data;
  end

  always_comb begin
    st_n    = st_q;
    stage_n = stage_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    rd_n    = rd_q;
    oe_n    = oe_q;
    obit_n  = obit_q;
    mack_n  = mack_q;
    stb_n   = 1'b0;
    waddr_n = wr_addr;
    wdata_n = wr_data;
    if (stop_det) begin
      st_n   = L_IDLE;
      oe_n   = 1'b0;
      obit_n = 1'b1;
    end else if (start_det) begin
      st_n    = L_RX;
      stage_n = SG_ADDR;
      bit_n   = '0;
      ptr_n   = '0;
      rd_n    = 1'b0;
      oe_n    = 1'b0;
      obit_n  = 1'b1;
    end else begin
      case (st_q)
        L_RX: begin
          if (scl_rise && (bit_q != CW'(BW_P))) begin
            sh_n  = {sh_q[BW_P-2:0], sda_s};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && (bit_q == CW'(BW_P))) begin
            if (stage_q == SG_ADDR) begin
              if (sh_q[BW_P-1:1] == ADDR_P) begin
                st_n    = L_RX_ACK;
                oe_n    = 1'b1;
                obit_n  = 1'b0;
                rd_n    = sh_q[0];
                stage_n = SG_CMD;
              end else begin
                st_n = L_IDLE;
              end
            end else begin
              st_n   = L_RX_ACK;
              oe_n   = 1'b1;
              obit_n = 1'b0;
              case (stage_q)
                SG_CMD:  stage_n = SG_CNT;
                SG_CNT:  stage_n = SG_DATA;
                default: stage_n = stage_q;
              endcase
              if ((stage_q == SG_DATA) && (ptr_q < PW'(NREG_P))) begin
                stb_n   = 1'b1;
                waddr_n = ptr_q[AW-1:0];
                wdata_n = sh_q;
                ptr_n   = ptr_q + 1'b1;
              end
            end
          end
        end
        L_RX_ACK: begin
          if (scl_fall) begin
            bit_n = '0;
            if (rd_q) begin
              st_n   = L_TX;
              sh_n   = tx_byte;
              obit_n = tx_byte[BW_P-1];
              ptr_n  = ptr_q + 1'b1;
            end else begin
              st_n   = L_RX;
              oe_n   = 1'b0;
              obit_n = 1'b1;
            end
          end
        end
        L_TX: begin
          if (scl_rise) begin
            bit_n = bit_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_q == CW'(BW_P)) begin
              st_n   = L_TX_ACK;
              oe_n   = 1'b0;
              obit_n = 1'b1;
            end else begin
              sh_n   = {sh_q[BW_P-2:0], 1'b0};
              obit_n = sh_q[BW_P-2];
            end
          end
        end
        L_TX_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q && (ptr_q <= PW'(NREG_P))) begin
              st_n   = L_TX;
              bit_n  = '0;
              sh_n   = tx_byte;
              oe_n   = 1'b1;
              obit_n = tx_byte[BW_P-1];
              ptr_n  = ptr_q + 1'b1;
            end else begin
              st_n = L_IDLE;
            end
          end
        end
        default: begin
          st_n = L_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= L_IDLE;
      stage_q <= SG_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      obit_q  <= 1'b1;
      mack_q  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      st_q    <= st_n;
      stage_q <= stage_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      rd_q    <= rd_n;
      oe_q    <= oe_n;
      obit_q  <= obit_n;
      mack_q  <= mack_n;
      wr_stb  <= stb_n;
      wr_addr <= waddr_n;
      wr_data <= wdata_n;
    end
  end

  always_comb begin
    sda_o  = obit_q;
    sda_oe = oe_q;
  end

  // R10: the driver is off whenever the link is idle
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_IDLE) |-> !oe_q);
  // R2: only data-stage bytes of a write reach the register bank
  a_r2_commit_in_data_stage: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ((stage_q == SG_DATA) && !rd_q));
  // R5: transmission happens only in a read transfer
  a_r5_tx_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_TX) |-> rd_q);
  // R4: the write pointer never passes the end of the bank
  a_r4_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |-> (ptr_q <= PW'(NREG_P)));
endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs import cfgbus_pkg::*; #(
  parameter int NREG_P = NREG,
  parameter int BW_P   = BW,
  parameter logic [NREG_P*BW_P-1:0] WMASK_P = WMASK,
  parameter logic [NREG_P*BW_P-1:0] DFLT_P  = DFLT,
  localparam int AW = $clog2(NREG_P)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [BW_P-1:0]        wdata,
  output logic [NREG_P*BW_P-1:0] stored
);
  for (genvar r = 0; r < NREG_P; r++) begin : g_row
    logic row_en;
    always_comb row_en = we && (waddr == AW'(r));
    for (genvar b = 0; b < BW_P; b++) begin : g_bit
      if (WMASK_P[r*BW_P+b]) begin : g_rw
        logic q_r;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q_r <= DFLT_P[r*BW_P+b];
          end else if (row_en) begin
            q_r <= wdata[b];
          end
        end
        assign stored[r*BW_P+b] = q_r;
      end else begin : g_ro
        assign stored[r*BW_P+b] = 1'b0;
      end
    end
  end

  // R3: stored bits change only under a write strobe
  a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(stored));
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave import cfgbus_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_o,
  output logic                 sda_oe,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic [LVL_W-1:0]     pin_lvl_i,
  output logic [NREG*BW-1:0]   cfg_o
);
  localparam int AW = $clog2(NREG);

  logic [1:0]         rst_q;
  logic               rst_core_n;
  logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0]      rd_addr, wr_addr;
  logic [BW-1:0]      rd_data, wr_data;
  logic               wr_stb;
  logic [NREG*BW-1:0] stored;
  logic [NREG*BW-1:0] ro_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  cfgbus_sync u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgbus_link u_link (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_o(sda_o), .sda_oe(sda_oe)
  );

  cfgbus_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .we(wr_stb),
    .waddr(wr_addr), .wdata(wr_data), .stored(stored)
  );

  always_comb begin
    ro_val = '0;
    ro_val[NREG*BW-1 -: BW] = ID_BYTE;
    ro_val[5*BW+4 +: STRAP_W] = strap_i;
    ro_val[6*BW+1 +: LVL_W] = pin_lvl_i;
    cfg_o = stored | ro_val;
  end

  assign rd_data = cfg_o[rd_addr*BW +: BW];

  // R7: the identification byte never moves
  a_r7_id_fixed: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_o[NREG*BW-1 -: BW] == ID_BYTE);
endmodule

// File: tb/cfgbus_slave_bench.sv
module cfgbus_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WDOG = 190000;
  localparam logic [63:0] B_WM = 64'h00C1_0FFF_FFFF_FFFF;
  localparam logic [63:0] B_DF = 64'h0000_0FFF_FFFF_FF00;

  logic clk, rst_n, scl, m_sda, sda_bus, sda_o, sda_oe;
  logic [3:0] strap;
  logic [4:0] lvl;
  logic [63:0] cfg;
  logic [63:0] exp_w;
  int errs, checks;

  assign sda_bus = m_sda & ~(sda_oe & ~sda_o);

  cfgbus_slave u_cfgbus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(strap),
    .pin_lvl_i(lvl), .cfg_o(cfg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] exp_cfg();
    logic [63:0] r;
    r = exp_w & B_WM;
    r[63:56] = 8'h29;
    r[47:44] = strap;
    r[53:49] = lvl;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic step();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b0; step(); m_sda = 1'b1; step();
    scl = 1'b1; step(); m_sda = 1'b0; step();
    scl = 1'b0; step();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; step(); scl = 1'b1; step(); m_sda = 1'b1; step();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; step(); scl = 1'b1; step(); step(); scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; step(); scl = 1'b1; step();
    acked = ~sda_bus;
    step(); scl = 1'b0; step();
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      step(); scl = 1'b1; step();
      b = {b[6:0], sda_bus};
      step(); scl = 1'b0;
    end
    m_sda = ~ack; step(); scl = 1'b1; step(); step(); scl = 1'b0; step();
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int n, input int k);
    return 8'(n * 37 + k * 11 + 1) ^ 8'hA5;
  endfunction

  // block write of n data bytes; returns number of missing acks
  task automatic wr_txn(input int n, output int nacks);
    logic a;
    nacks = 0;
    bus_start();
    put_byte(8'hD2, a); if (!a) nacks++;
    put_byte(8'h5A, a); if (!a) nacks++;
    put_byte(8'h33, a); if (!a) nacks++;
    for (int k = 0; k < n; k++) begin
      put_byte(pat(n, k), a); if (!a) nacks++;
      if (k < 8)
        exp_w[k*8 +: 8] = (exp_w[k*8 +: 8] & ~B_WM[k*8 +: 8]) | (pat(n, k) & B_WM[k*8 +: 8]);
    end
    bus_stop();
  endtask

  task automatic rd_check(input string tag);
    logic a;
    logic [7:0] c;
    logic [63:0] got, e;
    bus_start();
    put_byte(8'hD3, a);
    chk({tag, " R1 read address ack"}, 64'(a), 64'd1);
    get_byte(1'b1, c);
    chk({tag, " R5 byte count"}, 64'(c), 64'd8);
    e = exp_cfg();
    for (int k = 0; k < 8; k++) begin
      get_byte(k != 7, c);
      got[k*8 +: 8] = c;
    end
    bus_stop();
    chk({tag, " R5 read block"}, got, e);
  endtask

  initial begin
    errs = 0; checks = 0;
    repeat (WDOG) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int nk;
    logic a;
    logic [7:0] c;
    scl = 1'b1; m_sda = 1'b1; strap = 4'h0; lvl = 5'h00;
    rst_n = 1'b0;
    exp_w = B_DF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 reset defaults", cfg, exp_cfg());
    chk("R7 id after reset", 64'(cfg[63:56]), 64'h29);
    chk("R10 released after reset", 64'(sda_oe), 64'd0);

    // R3 R4 R8: every write length 0..10, with changing mirrored inputs
    for (int n = 0; n <= 10; n++) begin
      strap = 4'(n);
      lvl = 5'(n * 3 + 1);
      wr_txn(n, nk);
      chk($sformatf("R2 R3 R4 acks len=%0d", n), 64'(nk), 64'd0);
      repeat (4) @(negedge clk);
      chk($sformatf("R3 R8 R7 image len=%0d", n), cfg, exp_cfg());
      chk("R10 released after stop", 64'(sda_oe), 64'd0);
      rd_check($sformatf("len=%0d", n));
    end

    // R1: addresses one bit away from the valid pair get no ack
    for (int i = 0; i < 8; i++) begin
      bus_start(); put_byte(8'hD2 ^ (8'h1 << i), a);
      chk($sformatf("R1 no ack addr %h", 8'hD2 ^ (8'h1 << i)), 64'(a), 64'(i == 0));
      bus_stop();
    end
    bus_start(); put_byte(8'hD3 ^ 8'h80, a);
    chk("R1 no ack 53", 64'(a), 64'd0);
    bus_stop();

    // R1: traffic after a rejected address is ignored
    bus_start(); put_byte(8'hA0, a);
    chk("R1 reject A0", 64'(a), 64'd0);
    nk = 0;
    for (int k = 0; k < 4; k++) begin put_byte(8'h00, a); if (a) nk++; end
    chk("R1 later bytes unacked", 64'(nk), 64'd0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R1 bank unchanged", cfg, exp_cfg());

    // R3: a byte cut short by a stop is dropped
    bus_start(); put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h00, a);
    put_byte(8'h3C, a);
    exp_w[7:0] = 8'h3C;
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R3 partial byte dropped", cfg, exp_cfg());

    // R9: repeated start restarts at the command code and register 0
    bus_start(); put_byte(8'hD2, a); put_byte(8'h11, a); put_byte(8'h22, a);
    put_byte(8'h81, a); put_byte(8'h92, a);
    exp_w[15:8] = 8'h92;
    bus_start(); put_byte(8'hD2, a); put_byte(8'h44, a); put_byte(8'h55, a);
    put_byte(8'h6E, a);
    chk("R9 ack after restart", 64'(a), 64'd1);
    exp_w[7:0] = 8'h6E;
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R9 pointer restarted", cfg, exp_cfg());

    // R9: repeated start into a read
    bus_start(); put_byte(8'hD2, a); put_byte(8'h01, a);
    bus_start(); put_byte(8'hD3, a);
    get_byte(1'b1, c);
    chk("R9 restart into read count", 64'(c), 64'd8);
    get_byte(1'b0, c);
    chk("R9 restart into read reg0", 64'(c), 64'(exp_w[7:0]));
    repeat (Q) @(negedge clk);
    chk("R5 R10 released after nack", 64'(sda_oe), 64'd0);
    bus_stop();

    // R5: early NACK after count
    bus_start(); put_byte(8'hD3, a); get_byte(1'b0, c);
    chk("R5 count before nack", 64'(c), 64'd8);
    repeat (Q) @(negedge clk);
    chk("R5 R10 released after count nack", 64'(sda_oe), 64'd0);
    bus_stop();
    rd_check("final");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule